// File: doc/BRIEF.md
# Multiplexed external memory bus controller

This block sits between a processor core and an external memory bus on which the low address byte and the data byte share one 8-bit port. The core presents one request at a time: an instruction fetch, a data read or a data write. Each request carries either a full 16-bit address or an 8-bit indirect address. The controller runs a fixed bus cycle for the request. It drives the shared low port and its output enable, the high address port and the address latch pulse. It also drives one of three active-low strobes. Read and fetch results come back to the core with a one-cycle valid pulse.

The high port carries the upper address byte on fetches and on 16-bit data accesses. On 8-bit indirect data accesses, and whenever the bus is idle, it shows a port register that software writes through a separate write port. The controller is a five-state machine:
- `ST_IDLE` moves to `ST_LATCH` when a request is accepted.
- `ST_LATCH` moves to `ST_HOLD`.
- `ST_HOLD` moves to `ST_STROBE`.
- `ST_STROBE` stays for `STROBE_CYCLES` cycles and then moves to `ST_FINISH`.
- `ST_FINISH` returns to `ST_IDLE`.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: While synchronous reset `rst` is high and after it is released, `ale` is 0, `rd_n`, `wr_n` and `psen_n` are 1, `lo_oe` is 0 and the port register holds 8'hFF, so `hi_out` reads 8'hFF when idle.
- R2: `req_ready` is 1 only in `ST_IDLE`. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. A request held on `req_valid` while busy is not launched until the controller is idle again, and is then taken on the next edge.
- R3: The cycle after acceptance (`ST_LATCH`), `ale` is 1, `lo_oe` is 1 and `lo_out` carries address bits [7:0]. In the following cycle (`ST_HOLD`), `ale` is 0 and the same low address is still driven, with all strobes inactive.
- R4: For fetches, whatever the value of `req_wide`, and for data accesses with `req_wide`=1, `hi_out` carries address bits [15:8] from `ST_LATCH` through `ST_FINISH`.
- R5: For data reads and writes with `req_wide`=0, `hi_out` shows the port register rather than address bits, and `lo_out` carries `req_addr[7:0]`.
- R6: A data read holds `rd_n` low for `STROBE_CYCLES` cycles with `lo_oe`=0. `lo_in` is sampled on the edge at which `rd_n` returns high. `rsp_valid` is then 1 for exactly one cycle with that byte on `rsp_data`.
- R7: A data write holds `wr_n` low for `STROBE_CYCLES` cycles with `lo_out`=`req_wdata` and `lo_oe`=1. `lo_oe` stays 1 for the one cycle after `wr_n` rises and is 0 the cycle after that. No response pulse is produced.
- R8: A fetch uses `psen_n` as its strobe, with the same timing and data return as a read. `rd_n` and `wr_n` stay 1, and at most one strobe is ever low.
- R9: `req_kind` encoding: 2'b00 fetch, 2'b01 data read, 2'b10 data write, 2'b11 data read.
- R10: Asserting `sfr_we` loads `sfr_wdata` into the port register on the next edge. It appears on `hi_out` whenever the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core presents a request |
| req_ready | output | 1 | Controller idle; request is taken this edge |
| req_kind | input | 2 | Request type (R9 encoding) |
| req_wide | input | 1 | 1: 16-bit pointer, 0: 8-bit indirect |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with returned byte |
| rsp_data | output | 8 | Byte read from the bus |
| sfr_we | input | 1 | Port register write enable |
| sfr_wdata | input | 8 | Port register write value |
| lo_out | output | 8 | Shared low port output value |
| lo_oe | output | 1 | Shared low port output enable |
| lo_in | input | 8 | Shared low port input value |
| hi_out | output | 8 | High port output |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| psen_n | output | 1 | Program fetch strobe, active low |

## Verification
Every bus output is decoded straight from the state register and the latched request. A wrong state or a miscounted strobe therefore shows at the pins in the same cycle as a misplaced `ale`, an early or late strobe edge, or a wrongly timed `lo_oe`. A wrong high-byte source or a sample taken on the wrong edge shows as a bad `hi_out` during the access, or as a response byte that differs from the value the bus held at the strobe's rising edge. A request launched while busy is visible one cycle later as an extra `ale` pulse.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int HI_W   = ADDR_W - DATA_W;

    typedef enum logic [1:0] {
        KIND_FETCH  = 2'b00,
        KIND_READ   = 2'b01,
        KIND_WRITE  = 2'b10,
        KIND_READ_B = 2'b11
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LATCH,
        ST_HOLD,
        ST_STROBE,
        ST_FINISH
    } state_e;

    typedef struct packed {
        kind_e             kind;
        logic              wide;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } req_t;

    function automatic logic kind_is_write(input kind_e k);
        return k == KIND_WRITE;
    endfunction

    function automatic logic kind_is_fetch(input kind_e k);
        return k == KIND_FETCH;
    endfunction

endpackage

// File: rtl/xmem_fsm.sv
module xmem_fsm
    import xmem_pkg::*;
#(
    parameter int STROBE_CYCLES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   accept,
    output state_e state,
    output logic   strobe_last
);

    localparam int CW = (STROBE_CYCLES > 1) ? $clog2(STROBE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(STROBE_CYCLES - 1);

    state_e        nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            ST_IDLE:   if (accept) nxt = ST_LATCH;
            ST_LATCH:  nxt = ST_HOLD;
            ST_HOLD: begin
                nxt     = ST_STROBE;
                cnt_nxt = '0;
            end
            ST_STROBE: begin
                if (cnt == LAST) nxt = ST_FINISH;
                else             cnt_nxt = cnt + 1'b1;
            end
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    assign strobe_last = (state == ST_STROBE) && (cnt == LAST);

endmodule

// File: rtl/xmem_hisel.sv
module xmem_hisel #(
    parameter int           W          = 8,
    parameter logic [W-1:0] PORT_RESET = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic         use_addr,
    input  logic [W-1:0] addr_hi,
    output logic [W-1:0] hi_out
);

    logic [W-1:0] port_q;

    always_ff @(posedge clk) begin
        if (rst)     port_q <= PORT_RESET;
        else if (we) port_q <= wdata;
    end

    assign hi_out = use_addr ? addr_hi : port_q;

endmodule

// File: rtl/xmem_rdcap.sv
module xmem_rdcap #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sample,
    input  logic [W-1:0] bus_in,
    output logic         valid,
    output logic [W-1:0] data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= sample;
            if (sample) data <= bus_in;
        end
    end

endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
    import xmem_pkg::*;
#(
    parameter int                STROBE_CYCLES = 2,
    parameter logic [HI_W-1:0]   PORT_RESET    = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    input  logic              sfr_we,
    input  logic [HI_W-1:0]   sfr_wdata,
    output logic [DATA_W-1:0] lo_out,
    output logic              lo_oe,
    input  logic [DATA_W-1:0] lo_in,
    output logic [HI_W-1:0]   hi_out,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              psen_n
);

    state_e state;
    logic   strobe_last;
    logic   accept;
    req_t   req_q;
    logic   is_wr, is_fetch, use_addr;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (accept) begin
            req_q.kind  <= kind_e'(req_kind);
            req_q.wide  <= req_wide;
            req_q.addr  <= req_addr;
            req_q.wdata <= req_wdata;
        end
    end

    assign is_wr    = kind_is_write(req_q.kind);
    assign is_fetch = kind_is_fetch(req_q.kind);
    assign use_addr = (state != ST_IDLE) && (is_fetch || req_q.wide);

    xmem_fsm #(.STROBE_CYCLES(STROBE_CYCLES)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .state       (state),
        .strobe_last (strobe_last)
    );

    xmem_hisel #(.W(HI_W), .PORT_RESET(PORT_RESET)) u_hisel (
        .clk      (clk),
        .rst      (rst),
        .we       (sfr_we),
        .wdata    (sfr_wdata),
        .use_addr (use_addr),
        .addr_hi  (req_q.addr[ADDR_W-1:DATA_W]),
        .hi_out   (hi_out)
    );

    xmem_rdcap #(.W(DATA_W)) u_rdcap (
        .clk    (clk),
        .rst    (rst),
        .sample (strobe_last && !is_wr),
        .bus_in (lo_in),
        .valid  (rsp_valid),
        .data   (rsp_data)
    );

    always_comb begin
        ale    = 1'b0;
        lo_oe  = 1'b0;
        lo_out = req_q.addr[DATA_W-1:0];
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        psen_n = 1'b1;
        unique case (state)
            ST_IDLE: ;
            ST_LATCH: begin
                ale   = 1'b1;
                lo_oe = 1'b1;
            end
            ST_HOLD: lo_oe = 1'b1;
            ST_STROBE: begin
                if (is_wr) begin
                    lo_oe  = 1'b1;
                    lo_out = req_q.wdata;
                    wr_n   = 1'b0;
                end else if (is_fetch) begin
                    psen_n = 1'b0;
                end else begin
                    rd_n = 1'b0;
                end
            end
            ST_FINISH: begin
                if (is_wr) begin
                    lo_oe  = 1'b1;
                    lo_out = req_q.wdata;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/xmem_bus_ctrl_chk.sv
module xmem_bus_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic [7:0] lo_out,
    input logic       lo_oe,
    input logic       ale,
    input logic       rd_n,
    input logic       wr_n,
    input logic       psen_n
);

    p_one_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        $countones({~rd_n, ~wr_n, ~psen_n}) <= 1);

    p_ale_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ale) |=> !ale);

    p_ale_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        ale |-> (lo_oe && rd_n && wr_n && psen_n));

    p_addr_held_r3: assert property (@(posedge clk) disable iff (rst)
        ale |=> (lo_oe && $stable(lo_out)));

    p_accept_launch_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> ale);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!ale && !lo_oe && rd_n && wr_n && psen_n));

    p_read_release_r6: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !psen_n) |-> !lo_oe);

    p_rsp_at_rise_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(rd_n) || $rose(psen_n)) |-> rsp_valid);

    p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    p_write_drive_r7: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> lo_oe);

    p_write_tail_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_n) |-> (lo_oe ##1 !lo_oe));

endmodule

bind xmem_bus_ctrl xmem_bus_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .lo_out    (lo_out),
    .lo_oe     (lo_oe),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .psen_n    (psen_n)
);

// File: tb/xmem_bus_ctrl_bench.sv
`timescale 1ns/1ps
module xmem_bus_ctrl_bench;

    localparam int NSTR = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_wide;
    logic [1:0]  req_kind;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata, rsp_data, sfr_wdata, lo_out, lo_in, hi_out;
    logic        rsp_valid, sfr_we, lo_oe, ale, rd_n, wr_n, psen_n;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];
    logic [7:0] sfr_model;

    always #2.5 clk = ~clk;

    xmem_bus_ctrl #(.STROBE_CYCLES(NSTR)) u_xmem_bus_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_wide(req_wide), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .sfr_we(sfr_we), .sfr_wdata(sfr_wdata), .lo_out(lo_out), .lo_oe(lo_oe),
        .lo_in(lo_in), .hi_out(hi_out), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .psen_n(psen_n)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every response pulse (R6, R8)
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) check("R6 unexpected response", 16'(rsp_data), 16'hxxxx);
            else check("R6 response data", 16'(rsp_data), 16'(exp_q.pop_front()));
        end
    end

    task automatic set_sfr(input logic [7:0] v);
        sfr_we = 1'b1; sfr_wdata = v;
        @(negedge clk);
        sfr_we = 1'b0;
        sfr_model = v;
        @(negedge clk);
        check("R10 port register on hi_out", 16'(hi_out), 16'(v));
    endtask

    // driver: one full bus cycle, checked phase by phase from idle
    task automatic run_req(input logic [1:0] k, input logic w, input logic [15:0] a,
                           input logic [7:0] wd, input logic [7:0] rv,
                           input bit preloaded, input bit chain,
                           input logic [1:0] nk, input logic nw,
                           input logic [15:0] na, input logic [7:0] nwd);
        logic [7:0] exp_hi;
        bit wr, fe;
        wr = (k == 2'b10);
        fe = (k == 2'b00);
        exp_hi = (fe || w) ? a[15:8] : sfr_model;
        if (!preloaded) begin
            req_kind = k; req_wide = w; req_addr = a; req_wdata = wd; req_valid = 1'b1;
        end
        lo_in = ~rv;
        check("R2 ready before accept", 16'(req_ready), 16'd1);
        @(negedge clk);
        check("R3 ale in latch phase", 16'(ale), 16'd1);
        check("R3 lo_oe in latch phase", 16'(lo_oe), 16'd1);
        check("R3 low address", 16'(lo_out), 16'(a[7:0]));
        check((fe || w) ? "R4 high address byte" : "R5 port register on high port",
              16'(hi_out), 16'(exp_hi));
        check("R2 busy after accept", 16'(req_ready), 16'd0);
        if (chain) begin
            req_kind = nk; req_wide = nw; req_addr = na; req_wdata = nwd;
        end else begin
            req_valid = 1'b0;
        end
        if (!wr) exp_q.push_back(rv);
        @(negedge clk);
        check("R3 ale low in hold", 16'(ale), 16'd0);
        check("R3 address held", 16'({lo_oe, lo_out}), 16'({1'b1, a[7:0]}));
        check("R3 strobes idle in hold", 16'({rd_n, wr_n, psen_n}), 16'b111);
        for (int i = 0; i < NSTR; i++) begin
            if (i == NSTR - 1) lo_in = rv;
            @(negedge clk);
            if (wr) begin
                check("R7 write strobe", 16'({rd_n, wr_n, psen_n}), 16'b101);
                check("R7 write data driven", 16'({lo_oe, lo_out}), 16'({1'b1, wd}));
            end else if (fe) begin
                check("R8 fetch strobe", 16'({rd_n, wr_n, psen_n}), 16'b110);
                check("R8 port released", 16'(lo_oe), 16'd0);
            end else begin
                check("R9 R6 read strobe", 16'({rd_n, wr_n, psen_n}), 16'b011);
                check("R6 port released", 16'(lo_oe), 16'd0);
            end
            check((fe || w) ? "R4 high byte held" : "R5 high port held",
                  16'(hi_out), 16'(exp_hi));
            check("R2 held off while busy", 16'({req_ready, ale}), 16'b00);
        end
        @(negedge clk);
        lo_in = 8'h00;
        check("R6 R7 strobes released", 16'({rd_n, wr_n, psen_n}), 16'b111);
        if (wr) check("R7 oe held after wr_n rise", 16'({lo_oe, lo_out}), 16'({1'b1, wd}));
        else    check("R6 oe stays off", 16'(lo_oe), 16'd0);
        @(negedge clk);
        check("R2 idle again", 16'({req_ready, ale, lo_oe}), 16'b100);
        check("R10 idle high port shows register", 16'(hi_out), 16'(sfr_model));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_kind = 2'b00; req_wide = 1'b0;
        req_addr = '0; req_wdata = '0; sfr_we = 1'b0; sfr_wdata = '0; lo_in = '0;
        sfr_model = 8'hFF;
        repeat (4) @(negedge clk);
        check("R1 reset strobes/ale/oe", 16'({ale, rd_n, wr_n, psen_n, lo_oe}), 16'b01110);
        rst = 1'b0;
        @(negedge clk);
        check("R1 port register reset value", 16'(hi_out), 16'h00FF);
        check("R1 outputs idle after reset", 16'({ale, rd_n, wr_n, psen_n, lo_oe}), 16'b01110);

        run_req(2'b00, 1'b0, 16'h12A4, 8'h00, 8'h3C, 0, 0, 2'b00, 1'b0, 16'h0, 8'h0);
        run_req(2'b01, 1'b1, 16'hBEEF, 8'h00, 8'h81, 0, 0, 2'b00, 1'b0, 16'h0, 8'h0);
        run_req(2'b10, 1'b1, 16'h4020, 8'h5A, 8'h00, 0, 0, 2'b00, 1'b0, 16'h0, 8'h0);
        run_req(2'b01, 1'b0, 16'h7733, 8'h00, 8'hC6, 0, 0, 2'b00, 1'b0, 16'h0, 8'h0);
        set_sfr(8'h96);
        run_req(2'b01, 1'b0, 16'h0011, 8'h00, 8'h4B, 0, 0, 2'b00, 1'b0, 16'h0, 8'h0);
        run_req(2'b10, 1'b0, 16'hFF42, 8'hC3, 8'h00, 0, 0, 2'b00, 1'b0, 16'h0, 8'h0);
        run_req(2'b11, 1'b1, 16'h8001, 8'h00, 8'hE2, 0, 0, 2'b00, 1'b0, 16'h0, 8'h0);
        run_req(2'b00, 1'b1, 16'h00FE, 8'h00, 8'h17, 0, 0, 2'b00, 1'b0, 16'h0, 8'h0);
        // R2: second request held on req_valid during the first
        run_req(2'b01, 1'b1, 16'h1234, 8'h00, 8'h11, 0, 1, 2'b10, 1'b0, 16'h5566, 8'hE7);
        run_req(2'b10, 1'b0, 16'h5566, 8'hE7, 8'h00, 1, 0, 2'b00, 1'b0, 16'h0, 8'h0);

        repeat (3) @(negedge clk);
        check("R6 scoreboard drained", 16'(exp_q.size()), 16'd0);
        check("R7 no response after write", 16'(rsp_valid), 16'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule